// File: doc/BRIEF.md
# Cached Top-of-Stack Data Stack

This block is the data stack of a small 8-bit stack processor. The top-of-stack value lives in a dedicated register. Every deeper entry lives in an internal byte memory addressed by a data stack pointer. The memory entry at the pointer is the next-on-stack value, so both of the top two operands are always visible on the outputs.

The sequencer issues one stack operation at a time. It raises `start_i` with an operation code while the block is idle. The block then stays busy for the exact number of clocks that the operation costs, and raises `done_o` on the last of them. All state changes take effect at the clock edge that ends the `done_o` cycle.

Two drop variants also ask the return-stack logic for a subroutine return through `ret_req_o`. Register save and restore goes through the stack: a push can place the next-on-stack value, the pointer, or an external return pointer or flags byte on top. A pop can move the top into the pointer, or hand it to the return pointer or flags register through a write strobe.

Top module: `cached_dstack`

## Requirements
- R1: After reset the top-of-stack register is 0, the pointer is 0, every memory byte is 0, and `busy_o` and `done_o` are low.
- R2: Code 0 (push-top) adds one to the pointer and writes the top-of-stack into the memory byte at the new pointer. The top-of-stack is left unchanged, so the next-on-stack then equals it.
- R3: Codes 1 (drop-top) and 3 (drop-top with return) load the next-on-stack into the top-of-stack register, then subtract one from the pointer.
- R4: Codes 2 (drop-next) and 4 (drop-next with return) subtract one from the pointer and leave the top-of-stack unchanged.
- R5: Code 5 (register push) performs push-top and then loads a chosen value into the top-of-stack. `sel_i` picks the value: 0 = next-on-stack, 1 = pointer (before the push), 2 = `rsp_i`, 3 = `flags_i`. The inputs are sampled at the start edge.
- R6: Code 6 (register pop) behaves according to `sel_i`:
  - With `sel_i` 2 or 3, it pulses `reg_wr_o` in the `done_o` cycle with the top-of-stack on `reg_wr_data_o` and `sel_i` on `reg_wr_sel_o`, then performs drop-top.
  - With `sel_i` 1, it first copies the top-of-stack into the pointer and then performs drop-top.
  - With `sel_i` 0, it performs only drop-top.
- R7: An operation lasts its instruction-cycle count times `CLKS_PER_CYC` clocks (3 by default). The counts are: push-top 3, drop-top 3, drop-next 2, drop-top with return 6, drop-next with return 5, register push 4, register pop 4, code 7 1. `done_o` rises that many clocks after the start edge.
- R8: `ret_req_o` is a one-clock pulse, coincident with `done_o`, only for codes 3 and 4.
- R9: `start_i` is ignored while `busy_o` is high. Code 7 changes no state.
- R10: The pointer wraps modulo 256 in both directions, with no overflow or underflow indication.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin an operation (accepted only when idle) |
| op_i | input | 3 | Operation code |
| sel_i | input | 2 | Register select for codes 5 and 6 |
| rsp_i | input | 8 | Return stack pointer value to save |
| flags_i | input | 8 | Flags value to save |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | Last clock of the current operation |
| tos_o | output | 8 | Top-of-stack register |
| nos_o | output | 8 | Memory byte at the pointer |
| dsp_o | output | 8 | Data stack pointer |
| ret_req_o | output | 1 | Subroutine return request |
| reg_wr_o | output | 1 | Register restore strobe |
| reg_wr_sel_o | output | 2 | Register restored (2 = return pointer, 3 = flags) |
| reg_wr_data_o | output | 8 | Value restored |

## Verification
The stack is filled with register pushes of each select value, using distinct bytes, so that a wrong source or a push order swapped between the memory write and the top load shows up as a wrong byte. The drops and pops then unwind the stack. Here, distinct next-on-stack and top values separate drop-top from drop-next, and a pop into the pointer reveals whether the copy happens before or after the read. A start pulse during a busy window, and a walk of the pointer down past zero and back up, check the ignored-start and wrap rules. Every operation's done cycle is compared against its own cost.

// File: rtl/ds_pkg.sv
package ds_pkg;

    typedef enum logic [2:0] {
        OP_PUSH_TOS      = 3'd0,
        OP_DROP_TOS      = 3'd1,
        OP_DROP_NEXT     = 3'd2,
        OP_DROP_TOS_RET  = 3'd3,
        OP_DROP_NEXT_RET = 3'd4,
        OP_PUSH_REG      = 3'd5,
        OP_POP_REG       = 3'd6,
        OP_IDLE          = 3'd7
    } ds_op_e;

    typedef enum logic [1:0] {
        RS_NEXT  = 2'd0,
        RS_DSP   = 2'd1,
        RS_RSP   = 2'd2,
        RS_FLAGS = 2'd3
    } ds_reg_e;

    // instruction-cycle cost of each operation
    function automatic logic [2:0] op_cycles(ds_op_e op);
        case (op)
            OP_PUSH_TOS:      return 3'd3;
            OP_DROP_TOS:      return 3'd3;
            OP_DROP_NEXT:     return 3'd2;
            OP_DROP_TOS_RET:  return 3'd6;
            OP_DROP_NEXT_RET: return 3'd5;
            OP_PUSH_REG:      return 3'd4;
            OP_POP_REG:       return 3'd4;
            default:          return 3'd1;
        endcase
    endfunction

endpackage

// File: rtl/ds_cost.sv
module ds_cost
    import ds_pkg::*;
#(
    parameter int CLKS_PER_CYC = 3,
    parameter int CW           = 5
) (
    input  ds_op_e          op_i,
    output logic [CW-1:0]   clks_o
);

    assign clks_o = CW'(int'(op_cycles(op_i)) * CLKS_PER_CYC);

endmodule

// File: rtl/ds_mem.sv
module ds_mem #(
    parameter int AW = 8,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we_i,
    input  logic [AW-1:0] waddr_i,
    input  logic [DW-1:0] wdata_i,
    input  logic [AW-1:0] raddr_a_i,
    output logic [DW-1:0] rdata_a_o,
    input  logic [AW-1:0] raddr_b_i,
    output logic [DW-1:0] rdata_b_o
);

    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else if (we_i) begin
            mem_q[waddr_i] <= wdata_i;
        end
    end

    assign rdata_a_o = mem_q[raddr_a_i];
    assign rdata_b_o = mem_q[raddr_b_i];

endmodule

// File: rtl/cached_dstack.sv
module cached_dstack
    import ds_pkg::*;
#(
    parameter int AW           = 8,
    parameter int DW           = 8,
    parameter int CLKS_PER_CYC = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [2:0]    op_i,
    input  logic [1:0]    sel_i,
    input  logic [DW-1:0] rsp_i,
    input  logic [DW-1:0] flags_i,
    output logic          busy_o,
    output logic          done_o,
    output logic [DW-1:0] tos_o,
    output logic [DW-1:0] nos_o,
    output logic [AW-1:0] dsp_o,
    output logic          ret_req_o,
    output logic          reg_wr_o,
    output logic [1:0]    reg_wr_sel_o,
    output logic [DW-1:0] reg_wr_data_o
);

    localparam int CW = $clog2(7 * CLKS_PER_CYC + 1);

    typedef struct packed {
        logic          busy;
        logic [CW-1:0] cnt;
        ds_op_e        op;
        ds_reg_e       sel;
        logic [DW-1:0] ext;
        logic [DW-1:0] tos;
        logic [AW-1:0] dsp;
    } st_t;

    st_t st_d, st_q;

    logic          mem_we;
    logic [AW-1:0] mem_waddr;
    logic [DW-1:0] mem_wdata;
    logic [AW-1:0] rd_addr;
    logic [DW-1:0] nos_rd;
    logic [DW-1:0] commit_rd;
    logic [CW-1:0] cost_clks;
    logic          last_clk;
    logic [2:0]    op_cur;

    ds_cost #(
        .CLKS_PER_CYC (CLKS_PER_CYC),
        .CW           (CW)
    ) u_cost (
        .op_i   (ds_op_e'(op_i)),
        .clks_o (cost_clks)
    );

    ds_mem #(
        .AW (AW),
        .DW (DW)
    ) u_mem (
        .clk       (clk),
        .rst_n     (rst_n),
        .we_i      (mem_we),
        .waddr_i   (mem_waddr),
        .wdata_i   (mem_wdata),
        .raddr_a_i (st_q.dsp),
        .rdata_a_o (nos_rd),
        .raddr_b_i (rd_addr),
        .rdata_b_o (commit_rd)
    );

    assign last_clk = st_q.busy && (st_q.cnt == '0);
    assign op_cur   = st_q.op;

    always_comb begin
        st_d      = st_q;
        mem_we    = 1'b0;
        mem_waddr = st_q.dsp + 1'b1;
        mem_wdata = st_q.tos;
        // a pop into the pointer reads through the new pointer value
        if (st_q.op == OP_POP_REG && st_q.sel == RS_DSP) rd_addr = AW'(st_q.tos);
        else                                             rd_addr = st_q.dsp;

        if (!st_q.busy) begin
            if (start_i) begin
                st_d.busy = 1'b1;
                st_d.cnt  = cost_clks - 1'b1;
                st_d.op   = ds_op_e'(op_i);
                st_d.sel  = ds_reg_e'(sel_i);
                st_d.ext  = (ds_reg_e'(sel_i) == RS_FLAGS) ? flags_i : rsp_i;
            end
        end else if (!last_clk) begin
            st_d.cnt = st_q.cnt - 1'b1;
        end else begin
            st_d.busy = 1'b0;
            case (st_q.op)
                OP_PUSH_TOS: begin
                    mem_we   = 1'b1;
                    st_d.dsp = st_q.dsp + 1'b1;
                end
                OP_DROP_TOS, OP_DROP_TOS_RET: begin
                    st_d.tos = commit_rd;
                    st_d.dsp = st_q.dsp - 1'b1;
                end
                OP_DROP_NEXT, OP_DROP_NEXT_RET: begin
                    st_d.dsp = st_q.dsp - 1'b1;
                end
                OP_PUSH_REG: begin
                    mem_we   = 1'b1;
                    st_d.dsp = st_q.dsp + 1'b1;
                    case (st_q.sel)
                        RS_NEXT: st_d.tos = nos_rd;
                        RS_DSP:  st_d.tos = DW'(st_q.dsp);
                        default: st_d.tos = st_q.ext;
                    endcase
                end
                OP_POP_REG: begin
                    st_d.tos = commit_rd;
                    st_d.dsp = rd_addr - 1'b1;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{busy: 1'b0, cnt: '0, op: OP_IDLE, sel: RS_NEXT,
                      ext: '0, tos: '0, dsp: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign busy_o        = st_q.busy;
    assign done_o        = last_clk;
    assign tos_o         = st_q.tos;
    assign nos_o         = nos_rd;
    assign dsp_o         = st_q.dsp;
    assign ret_req_o     = last_clk &&
                           (st_q.op == OP_DROP_TOS_RET || st_q.op == OP_DROP_NEXT_RET);
    assign reg_wr_o      = last_clk && (st_q.op == OP_POP_REG) &&
                           (st_q.sel == RS_RSP || st_q.sel == RS_FLAGS);
    assign reg_wr_sel_o  = st_q.sel;
    assign reg_wr_data_o = st_q.tos;

endmodule

// File: rtl/ds_stack_chk.sv
module ds_stack_chk #(
    parameter int AW = 8,
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start_i,
    input logic          busy_o,
    input logic          done_o,
    input logic          ret_req_o,
    input logic [DW-1:0] tos_o,
    input logic [DW-1:0] nos_o,
    input logic [AW-1:0] dsp_o,
    input logic [2:0]    op_cur
);

    a_r2_push_tos: assert property (@(posedge clk) disable iff (!rst_n)
        done_o && op_cur == 3'd0 |=>
            dsp_o == AW'($past(dsp_o) + 1'b1) && tos_o == $past(tos_o) && nos_o == $past(tos_o));

    a_r3_drop_tos: assert property (@(posedge clk) disable iff (!rst_n)
        done_o && (op_cur == 3'd1 || op_cur == 3'd3) |=>
            tos_o == $past(nos_o) && dsp_o == AW'($past(dsp_o) - 1'b1));

    a_r4_drop_next: assert property (@(posedge clk) disable iff (!rst_n)
        done_o && (op_cur == 3'd2 || op_cur == 3'd4) |=>
            dsp_o == AW'($past(dsp_o) - 1'b1) && $stable(tos_o));

    a_r8_ret_single: assert property (@(posedge clk) disable iff (!rst_n)
        ret_req_o |=> !ret_req_o && !busy_o);

    a_r9_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o && !done_o |=> busy_o && $stable(op_cur) && $stable(dsp_o) && $stable(tos_o));

    a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o && !start_i |=> !busy_o && $stable(dsp_o) && $stable(tos_o));

endmodule

bind cached_dstack ds_stack_chk #(
    .AW (AW),
    .DW (DW)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .ret_req_o (ret_req_o),
    .tos_o     (tos_o),
    .nos_o     (nos_o),
    .dsp_o     (dsp_o),
    .op_cur    (op_cur)
);

// File: tb/tb_cached_dstack.sv
module tb_cached_dstack;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic [2:0] op_i = '0;
    logic [1:0] sel_i = '0;
    logic [7:0] rsp_i = '0;
    logic [7:0] flags_i = '0;
    logic       busy_o, done_o, ret_req_o, reg_wr_o;
    logic [7:0] tos_o, nos_o, dsp_o, reg_wr_data_o;
    logic [1:0] reg_wr_sel_o;

    cached_dstack dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .start_i       (start_i),
        .op_i          (op_i),
        .sel_i         (sel_i),
        .rsp_i         (rsp_i),
        .flags_i       (flags_i),
        .busy_o        (busy_o),
        .done_o        (done_o),
        .tos_o         (tos_o),
        .nos_o         (nos_o),
        .dsp_o         (dsp_o),
        .ret_req_o     (ret_req_o),
        .reg_wr_o      (reg_wr_o),
        .reg_wr_sel_o  (reg_wr_sel_o),
        .reg_wr_data_o (reg_wr_data_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct {
        int         t0;
        int         lat;
        bit         ret;
        bit         wr;
        logic [1:0] wsel;
        logic [7:0] wdata;
        logic [7:0] tos;
        logic [7:0] nos;
        logic [7:0] dsp;
        string      tag;
    } exp_t;

    exp_t       sb_q[$];
    int         total = 0;
    int         bad = 0;
    int         cyc = 0;
    int         issued = 0;
    int         handled = 0;
    bit         finished = 0;
    logic [7:0] m_mem [256];
    logic [7:0] m_tos, m_dsp;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    // driver: computes the expected result from the requirements and queues it
    task automatic issue(input logic [2:0] op, input logic [1:0] sel,
                         input logic [7:0] rsp, input logic [7:0] fl,
                         input bit poke, input string tag);
        exp_t e;
        int   cost;
        logic [7:0] v;
        case (op)
            3'd0, 3'd1: cost = 3;
            3'd2:       cost = 2;
            3'd3:       cost = 6;
            3'd4:       cost = 5;
            3'd5, 3'd6: cost = 4;
            default:    cost = 1;
        endcase
        e.lat = cost * 3;
        e.ret = (op == 3'd3 || op == 3'd4);
        e.wr = 0; e.wsel = sel; e.wdata = m_tos; e.tag = tag;
        case (op)
            3'd0: begin m_dsp = m_dsp + 1; m_mem[m_dsp] = m_tos; end
            3'd1, 3'd3: begin m_tos = m_mem[m_dsp]; m_dsp = m_dsp - 1; end
            3'd2, 3'd4: m_dsp = m_dsp - 1;
            3'd5: begin
                case (sel)
                    2'd0: v = m_mem[m_dsp];
                    2'd1: v = m_dsp;
                    2'd2: v = rsp;
                    default: v = fl;
                endcase
                m_dsp = m_dsp + 1; m_mem[m_dsp] = m_tos; m_tos = v;
            end
            3'd6: begin
                e.wr = (sel >= 2'd2);
                if (sel == 2'd1) m_dsp = m_tos;
                m_tos = m_mem[m_dsp]; m_dsp = m_dsp - 1;
            end
            default: ;
        endcase
        e.tos = m_tos; e.dsp = m_dsp; e.nos = m_mem[m_dsp];
        @(negedge clk);
        e.t0 = cyc;
        sb_q.push_back(e);
        issued++;
        start_i = 1'b1; op_i = op; sel_i = sel; rsp_i = rsp; flags_i = fl;
        @(negedge clk);
        start_i = 1'b0;
        if (poke) begin
            // a second request while busy must be dropped (R9)
            op_i = 3'd0; sel_i = 2'd3; rsp_i = 8'hEE; flags_i = 8'hEE;
            start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
        end
        rsp_i = 8'h00; flags_i = 8'h00;
        wait (handled == issued);
    endtask

    // monitor: pops the queue when the design finishes an operation
    always begin
        exp_t e;
        @(negedge clk);
        if (rst_n && ret_req_o && !done_o) begin
            total++; bad++;
            $display("FAIL R8 ret_req outside done: actual=1 expected=0");
        end
        if (rst_n && done_o === 1'b1) begin
            if (sb_q.size() == 0) begin
                total++; bad++;
                $display("FAIL R9 unexpected done: actual=1 expected=0");
            end else begin
                e = sb_q.pop_front();
                chk(cyc - e.t0 == e.lat, "R7", {e.tag, " latency"}, cyc - e.t0, e.lat);
                chk(ret_req_o == e.ret, "R8", {e.tag, " ret_req"}, ret_req_o, e.ret);
                chk(reg_wr_o == e.wr, "R6", {e.tag, " reg_wr"}, reg_wr_o, e.wr);
                if (e.wr) begin
                    chk(reg_wr_sel_o == e.wsel, "R6", {e.tag, " reg_wr_sel"}, reg_wr_sel_o, e.wsel);
                    chk(reg_wr_data_o == e.wdata, "R6", {e.tag, " reg_wr_data"}, reg_wr_data_o, e.wdata);
                end
                @(negedge clk);
                chk(tos_o == e.tos, e.tag, "tos", tos_o, e.tos);
                chk(dsp_o == e.dsp, e.tag, "dsp", dsp_o, e.dsp);
                chk(nos_o == e.nos, e.tag, "nos", nos_o, e.nos);
                chk(busy_o == 1'b0, e.tag, "busy after done", busy_o, 0);
                handled++;
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        total++; bad++;
        $display("FAIL watchdog expired: actual=%0d expected=%0d", handled, issued);
        summary();
    end

    initial begin
        for (int i = 0; i < 256; i++) m_mem[i] = 8'h00;
        m_tos = 8'h00; m_dsp = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(tos_o == 8'h00, "R1", "tos", tos_o, 0);
        chk(dsp_o == 8'h00, "R1", "dsp", dsp_o, 0);
        chk(nos_o == 8'h00, "R1", "nos", nos_o, 0);
        chk(busy_o == 1'b0, "R1", "busy", busy_o, 0);
        chk(done_o == 1'b0, "R1", "done", done_o, 0);

        issue(3'd5, 2'd2, 8'h5A, 8'h00, 0, "R5");   // push return pointer
        issue(3'd0, 2'd0, 8'h00, 8'h00, 0, "R2");   // push-top
        issue(3'd5, 2'd3, 8'h00, 8'hC3, 0, "R5");   // push flags
        issue(3'd5, 2'd0, 8'h00, 8'h00, 0, "R5");   // push next
        issue(3'd5, 2'd1, 8'h00, 8'h00, 0, "R5");   // push pointer
        issue(3'd1, 2'd0, 8'h00, 8'h00, 0, "R3");   // drop-top
        issue(3'd7, 2'd0, 8'h00, 8'h00, 0, "R9");   // no-op code
        issue(3'd2, 2'd0, 8'h00, 8'h00, 0, "R4");   // drop-next
        issue(3'd5, 2'd2, 8'h11, 8'h00, 0, "R5");
        issue(3'd5, 2'd3, 8'h00, 8'h77, 0, "R5");
        issue(3'd6, 2'd2, 8'h00, 8'h00, 0, "R6");   // pop to return pointer
        issue(3'd6, 2'd3, 8'h00, 8'h00, 0, "R6");   // pop to flags
        issue(3'd3, 2'd0, 8'h00, 8'h00, 0, "R8");   // drop-top with return
        issue(3'd5, 2'd2, 8'h3C, 8'h00, 0, "R5");
        issue(3'd4, 2'd0, 8'h00, 8'h00, 0, "R8");   // drop-next with return
        issue(3'd0, 2'd0, 8'h00, 8'h00, 1, "R9");   // start pulsed while busy
        issue(3'd5, 2'd2, 8'h02, 8'h00, 0, "R5");
        issue(3'd6, 2'd1, 8'h00, 8'h00, 0, "R6");   // pop into pointer
        issue(3'd5, 2'd3, 8'h00, 8'h9D, 0, "R5");
        issue(3'd6, 2'd0, 8'h00, 8'h00, 0, "R6");   // pop with select 0
        while (m_dsp != 8'h00) issue(3'd2, 2'd0, 8'h00, 8'h00, 0, "R4");
        issue(3'd2, 2'd0, 8'h00, 8'h00, 0, "R10");  // 0 -> 255
        issue(3'd0, 2'd0, 8'h00, 8'h00, 0, "R10");  // 255 -> 0
        issue(3'd1, 2'd0, 8'h00, 8'h00, 0, "R10");  // 0 -> 255 via drop-top
        repeat (4) @(negedge clk);
        summary();
    end

endmodule